// File: doc/BRIEF.md
# Refresh-Locked Slow Clock Divider

This block derives a slow, square clock from the scan controller's refresh events instead of from the system clock. Software or a test rig raises the enable input while presenting a divisor N on the data pins. The rising edge of the enable latches N, and from then on the slow clock changes level once for every N+1 refresh pulses. Its period is therefore 2·(N+1) refreshes, and the design that receives it is always sampled at a consistent phase of the scan sequence.

While the block is enabled, the slow clock takes the place of the clock bit (bit 0) in the data word handed to the selected design. The same level also appears on a dedicated output pin. While the block is disabled, that bit carries the pin value unchanged, and the slow clock output rests low. Scan shifting and refresh generation are handled elsewhere. This block only watches the one-cycle refresh pulse.

Top module: `slowclk_gen`

## Requirements
- R1: The divisor N is taken from `pins_i` at the first clock edge where `clk_div_en_i` is high after having been low. Later changes on `pins_i` while the enable stays high do not alter N.
- R2: At every clock edge where `clk_div_en_i` is low, the refresh counter and the slow clock level are cleared, so `slow_clk_o` is 0 from the next cycle on.
- R3: With divisor N, `slow_clk_o` goes high on the (N+1)-th counted refresh pulse after enabling. It then toggles on every further N+1 pulses, so after k counted pulses its level is floor(k/(N+1)) mod 2. N ranges over the full 0..255.
- R4: The slow clock changes level only at an edge where `refresh_i` is high. A refresh pulse that arrives in the same cycle as the enable's rising edge is not counted.
- R5: While enabled (from the edge after the enable rises), `design_in_o[0]` equals `slow_clk_o`. Bits 7..1 always equal `pins_i[7:1]`.
- R6: While not enabled (from the edge after the enable falls, and out of reset), `design_in_o[0]` equals `pins_i[0]`.
- R7: After reset, `slow_clk_o` is 0 and `design_in_o` equals `pins_i`.
- R8: Raising the enable again after a fall recaptures N and restarts the phase, with the count at 0 and the level low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_div_en_i | input | 1 | Divider enable; its rising edge latches the divisor |
| pins_i | input | 8 | Data pins: divisor source and design input word |
| refresh_i | input | 1 | One-cycle pulse per completed scan refresh |
| design_in_o | output | 8 | Input word to the selected design, bit 0 replaced when enabled |
| slow_clk_o | output | 1 | Slow clock level |

## Verification
The bench runs the divider at N = 0, 1, 3 and 255 and checks the level after every refresh pulse. A counter that is off by one would toggle one pulse early or late. An 8-bit counter that wraps badly would never toggle at N = 255. The bench inserts idle cycles between pulses and raises a refresh in the same cycle as the enable. A design that toggled on the system clock or counted that early pulse would lead the expected phase. It changes the pins after capture, disables mid-period and re-enables with a new N. A design that re-read the pins, kept its level after the fall, or resumed the old phase would show the wrong level or the wrong bit 0.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_CLK_BIT = 0;

  typedef struct packed {
    logic active;
    logic rise;
  } en_state_t;
endpackage

// File: rtl/slowclk_capture.sv
module slowclk_capture
  import slowclk_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] pins_i,
  output en_state_t         state_o,
  output logic [DATA_W-1:0] div_n_o
);
  logic              en_q;
  logic [DATA_W-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      n_q  <= '0;
    end else begin
      en_q <= en_i;
      if (en_i && !en_q) n_q <= pins_i;
    end
  end

  assign state_o.active = en_q;
  assign state_o.rise   = en_i & ~en_q;
  assign div_n_o        = n_q;

  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_q) |=> (n_q == $past(pins_i)));
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q) |=> $stable(n_q));
endmodule

// File: rtl/slowclk_divcnt.sv
module slowclk_divcnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             refresh_i,
  input  logic [CNT_W-1:0] div_n_i,
  output logic             slow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             slow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else if (!en_i || rise_i) begin
      // restart phase on disable or fresh enable
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else if (refresh_i) begin
      if (cnt_q == div_n_i) begin
        cnt_q  <= '0;
        slow_q <= ~slow_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign slow_o = slow_q;

  a_r2_clear_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!slow_q && cnt_q == '0));
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !rise_i) |-> (cnt_q <= div_n_i));
  a_r4_refresh_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !rise_i && !refresh_i) |=> $stable(slow_q));
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (!slow_q && cnt_q == '0));
endmodule

// File: rtl/slowclk_inmux.sv
module slowclk_inmux #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_BIT = 0
) (
  input  logic              sel_i,
  input  logic              slow_i,
  input  logic [DATA_W-1:0] pins_i,
  output logic [DATA_W-1:0] word_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == CLK_BIT) begin : g_clk
      assign word_o[i] = sel_i ? slow_i : pins_i[i];
    end else begin : g_pass
      assign word_o[i] = pins_i[i];
    end
  end
endmodule

// File: rtl/slowclk_gen.sv
module slowclk_gen
  import slowclk_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned CLK_BIT = DEF_CLK_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_div_en_i,
  input  logic [DATA_W-1:0] pins_i,
  input  logic              refresh_i,
  output logic [DATA_W-1:0] design_in_o,
  output logic              slow_clk_o
);
  localparam int unsigned CNT_W = DATA_W;

  en_state_t        en_st;
  logic [CNT_W-1:0] div_n;
  logic             slow;

  slowclk_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (clk_div_en_i),
    .pins_i  (pins_i),
    .state_o (en_st),
    .div_n_o (div_n)
  );

  slowclk_divcnt #(.CNT_W(CNT_W)) u_divcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (clk_div_en_i),
    .rise_i    (en_st.rise),
    .refresh_i (refresh_i),
    .div_n_i   (div_n),
    .slow_o    (slow)
  );

  slowclk_inmux #(.DATA_W(DATA_W), .CLK_BIT(CLK_BIT)) u_inmux (
    .sel_i  (en_st.active),
    .slow_i (slow),
    .pins_i (pins_i),
    .word_o (design_in_o)
  );

  assign slow_clk_o = slow;

  a_r6_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_div_en_i |=> (design_in_o[CLK_BIT] == pins_i[CLK_BIT]));
  a_r5_slow_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_div_en_i && $past(clk_div_en_i)) |-> (design_in_o[CLK_BIT] == slow_clk_o));
endmodule

// File: tb/slowclk_gen_tb_top.sv
`timescale 1ns/1ps
module slowclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] pins = 8'h00;
  logic       refresh = 1'b0;
  logic [7:0] word;
  logic       slow;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  slowclk_gen dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .clk_div_en_i (en),
    .pins_i       (pins),
    .refresh_i    (refresh),
    .design_in_o  (word),
    .slow_clk_o   (slow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int gap);
    @(negedge clk) refresh = 1'b1;
    @(negedge clk) refresh = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic enable_with(input logic [7:0] n);
    @(negedge clk) begin en = 1'b1; pins = n; end
    @(negedge clk);
  endtask

  task automatic disable_div();
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk("R2 slow low after fall", slow, 0);
    pins = 8'h5B;
    #1 chk("R6 bit0 passthrough", word[0], 1);
    pins = 8'h5A;
    #1 chk("R6 bit0 passthrough low", word[0], 0);
  endtask

  task automatic t_reset();
    pins = 8'hA5;
    #1;
    chk("R7 slow after reset", slow, 0);
    chk("R7 word after reset", word, 8'hA5);
  endtask

  task automatic t_divide(input logic [7:0] n, input int pulses, input int gap);
    int errs = 0;
    enable_with(n);
    chk("R3 level after enable", slow, 0);
    pins = ~n | 8'h01;
    for (int k = 1; k <= pulses; k++) begin
      int e;
      pulse(gap);
      e = (k / (int'(n) + 1)) % 2;
      if (slow !== e[0] || word[0] !== slow || word[7:1] !== pins[7:1]) begin
        errs++;
        if (errs < 4)
          $display("FAIL R3/R1/R5 n=%0d pulse=%0d actual=%0d expected=%0d word=%0h",
                   n, k, slow, e, word);
      end
    end
    checks++;
    if (errs != 0) fails++;
    chk("R5 bit0 follows slow", word[0], slow);
    disable_div();
  endtask

  task automatic t_idle_gap();
    enable_with(8'd0);
    pulse(0);
    chk("R3 first toggle n=0", slow, 1);
    repeat (7) @(negedge clk);
    chk("R4 stable without refresh", slow, 1);
    disable_div();
  endtask

  task automatic t_rise_refresh();
    @(negedge clk) begin en = 1'b1; pins = 8'd0; refresh = 1'b1; end
    @(negedge clk) refresh = 1'b0;
    chk("R4 refresh in rise cycle ignored", slow, 0);
    pulse(1);
    chk("R4 first counted pulse", slow, 1);
    disable_div();
  endtask

  task automatic t_restart();
    enable_with(8'd2);
    for (int k = 0; k < 4; k++) pulse(0);
    chk("R3 n=2 after 4 pulses", slow, 1);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk("R2 cleared mid-period", slow, 0);
    enable_with(8'd1);
    chk("R8 restart low", slow, 0);
    pulse(0);
    chk("R8 no toggle after 1 of 2", slow, 0);
    pulse(0);
    chk("R8 toggle after 2 with new N", slow, 1);
    disable_div();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divide(8'd0, 8, 0);
    t_divide(8'd1, 10, 1);
    t_divide(8'd3, 17, 2);
    t_divide(8'd255, 520, 0);
    t_idle_gap();
    t_rise_refresh();
    t_restart();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule